// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an internal request bus and an external 512K x 8 asynchronous static RAM. It takes one single-beat read or write at a time over a valid/ready handshake. It then drives the RAM's active-low chip select, output enable and write enable, a 19-bit address, and an 8-bit data bus that is split into out, in and output-enable. Every phase length comes from the part's AC limits for the chosen speed grade (70, 85 or 100 ns). Each limit is rounded up to whole cycles of the configured clock period, so the same RTL meets timing at any clock rate without hand-set wait states.

Writes use a single overlap window. Write enable and chip select fall on the same edge and rise on the same edge, so write enable is never later than chip select and the RAM keeps its outputs off during the write. The controller drives data only inside that window. Reads hold write enable high, lower chip select and output enable together with a stable address, and sample the data bus at the first clock edge that meets the slowest access time. A recovery phase after each access pads the access to the minimum cycle time. It always leaves at least one cycle with the bus released.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and on release, sram_cs_no, sram_we_no and sram_oe_no are 1, sram_dq_oe_o is 0, rsp_valid_o is 0 and cmd_ready_o is 1.
- R2: cmd_ready_o is 1 only while the sequencer is idle and all strobes are high. A request held on cmd_valid_i while busy is not taken and leaves the RAM contents unchanged.
- R3: A write holds sram_cs_no and sram_we_no low together, falling on the same edge and rising on the same edge. The window lasts N_WS = max(ceil(tWP), ceil(tCW), ceil(tAW), ceil(tDW)) cycles. sram_cs_no is never low with both sram_we_no and sram_oe_no high.
- R4: sram_dq_oe_o is 1 exactly during the write window, with sram_dq_o equal to the request's data. It is never 1 while sram_oe_no is 0.
- R5: A write keeps cmd_ready_o low for N_WS + N_WREC cycles, where N_WREC = max(1, ceil(tWR), ceil(tWC) - N_WS).
- R6: A read holds sram_cs_no and sram_oe_no low with sram_we_no high for N_RA = max(ceil(tAA), ceil(tACS), ceil(tOE)) cycles. The sequencer samples sram_dq_i at the edge that ends the window. rsp_valid_o is 1 for the following single cycle, with rsp_rdata_o holding the sampled byte N_RA cycles after the accepting edge.
- R7: A read keeps cmd_ready_o low for max(N_RA + 1, ceil(tRC)) cycles.
- R8: sram_addr_o equals the accepted cmd_addr_i and does not change while sram_cs_no is low.
- R9: Every limit converts to cycles as ceil(ns / CLK_PERIOD_NS) with a minimum of 1. SPEED_GRADE 70, 85 or 100 selects these limits (ns):

  | Grade | tRC, tAA, tACS, tWC | tOE | tCW, tAW | tWP | tWR | tDW |
  |-------|---------------------|-----|----------|-----|-----|-----|
  | 70    | 70                  | 35  | 60       | 50  | 0   | 30  |
  | 85    | 85                  | 45  | 75       | 55  | 5   | 35  |
  | 100   | 100                 | 50  | 80       | 60  | 5   | 40  |

- R10: A byte written to an address reads back unchanged. This holds at the lowest and highest addresses and for all-zero, all-one, alternating and walking-one data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Request present |
| cmd_ready_o | output | 1 | Request taken on this edge when valid |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 19 | Byte address |
| cmd_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | 8 | Read byte |
| sram_addr_o | output | 19 | RAM address |
| sram_cs_no | output | 1 | RAM chip select, active low |
| sram_oe_no | output | 1 | RAM output enable, active low |
| sram_we_no | output | 1 | RAM write enable, active low |
| sram_dq_o | output | 8 | Data toward the RAM |
| sram_dq_i | input | 8 | Data from the RAM |
| sram_dq_oe_o | output | 1 | Data driver enable toward the RAM |

## Verification
The bench builds the block with SPEED_GRADE = 100 and CLK_PERIOD_NS = 8. This gives a 10-cycle write window, 3 recovery cycles and a 13-cycle read window. At this point the write-cycle minimum, not the write-recovery limit, sets the recovery length, so the padding path of R5 is reached. The read window is bounded by the address access time, while the output-enable time is shorter, so the max selection of R6 is exercised. The bench's RAM model returns corrupted data until the read strobes have been low for the required count, and it measures every write window and idle gap in cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSTB,
    ST_WREC,
    ST_RACC,
    ST_RREC
  } state_e;

  typedef enum logic [3:0] {
    L_RC, L_AA, L_ACS, L_OE, L_WC, L_CW, L_AW, L_WP, L_WR, L_DW
  } lim_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // limit in ns for a grade; grades above 85 use the slowest set
  function automatic int unsigned lim_ns(int unsigned grade, lim_e l);
    int unsigned g;
    g = (grade <= 70) ? 0 : (grade <= 85) ? 1 : 2;
    case (l)
      L_RC, L_AA, L_ACS, L_WC: return (g == 0) ? 70 : (g == 1) ? 85 : 100;
      L_OE:                    return (g == 0) ? 35 : (g == 1) ? 45 : 50;
      L_CW, L_AW:              return (g == 0) ? 60 : (g == 1) ? 75 : 80;
      L_WP:                    return (g == 0) ? 50 : (g == 1) ? 55 : 60;
      L_WR:                    return (g == 0) ? 0  : 5;
      L_DW:                    return (g == 0) ? 30 : (g == 1) ? 35 : 40;
      default:                 return 0;
    endcase
  endfunction

  function automatic int unsigned to_cyc(int unsigned ns, int unsigned tck);
    return max2(1, (ns + tck - 1) / tck);
  endfunction

  function automatic int unsigned lim_cyc(int unsigned grade, int unsigned tck, lim_e l);
    return to_cyc(lim_ns(grade, l), tck);
  endfunction

  function automatic int unsigned wstb_cycles(int unsigned grade, int unsigned tck);
    return max2(max2(lim_cyc(grade, tck, L_WP), lim_cyc(grade, tck, L_CW)),
                max2(lim_cyc(grade, tck, L_AW), lim_cyc(grade, tck, L_DW)));
  endfunction

  function automatic int unsigned wrec_cycles(int unsigned grade, int unsigned tck);
    int unsigned ws, wc;
    ws = wstb_cycles(grade, tck);
    wc = lim_cyc(grade, tck, L_WC);
    return max2(lim_cyc(grade, tck, L_WR), (wc > ws) ? wc - ws : 1);
  endfunction

  function automatic int unsigned racc_cycles(int unsigned grade, int unsigned tck);
    return max2(max2(lim_cyc(grade, tck, L_AA), lim_cyc(grade, tck, L_ACS)),
                lim_cyc(grade, tck, L_OE));
  endfunction

  function automatic int unsigned rrec_cycles(int unsigned grade, int unsigned tck);
    int unsigned ra, rc;
    ra = racc_cycles(grade, tck);
    rc = lim_cyc(grade, tck, L_RC);
    return (rc > ra) ? max2(1, rc - ra) : 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_timing.sv
module sram_ctrl_timing #(
  parameter int unsigned SPEED_GRADE   = 70,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned CNT_W         = 8
) (
  output logic [CNT_W-1:0] n_wstb_o,
  output logic [CNT_W-1:0] n_wrec_o,
  output logic [CNT_W-1:0] n_racc_o,
  output logic [CNT_W-1:0] n_rrec_o
);
  import sram_ctrl_pkg::*;

  localparam int unsigned NWS = wstb_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned NWR = wrec_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned NRA = racc_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned NRR = rrec_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned NMAX = max2(max2(NWS, NWR), max2(NRA, NRR));

  if (SPEED_GRADE != 70 && SPEED_GRADE != 85 && SPEED_GRADE != 100) begin : g_bad_grade
    $fatal(1, "sram_ctrl_timing: SPEED_GRADE must be 70, 85 or 100");
  end
  if (NMAX >= (1 << CNT_W)) begin : g_bad_width
    $fatal(1, "sram_ctrl_timing: CNT_W too small for clock period");
  end

  assign n_wstb_o = CNT_W'(NWS);
  assign n_wrec_o = CNT_W'(NWR);
  assign n_racc_o = CNT_W'(NRA);
  assign n_rrec_o = CNT_W'(NRR);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm #(
  parameter int unsigned CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_write_i,
  input  logic [CNT_W-1:0]      n_wstb_i,
  input  logic [CNT_W-1:0]      n_wrec_i,
  input  logic [CNT_W-1:0]      n_racc_i,
  input  logic [CNT_W-1:0]      n_rrec_i,
  output logic                  cmd_ready_o,
  output logic                  accept_o,
  output logic                  sample_o,
  output sram_ctrl_pkg::state_e state_d_o
);
  import sram_ctrl_pkg::*;

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last        = (cnt_q == '0);
  assign cmd_ready_o = (state_q == ST_IDLE);
  assign accept_o    = cmd_ready_o && cmd_valid_i;
  assign sample_o    = (state_q == ST_RACC) && last;
  assign state_d_o   = state_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = last ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d = cmd_write_i ? ST_WSTB : ST_RACC;
        cnt_d   = (cmd_write_i ? n_wstb_i : n_racc_i) - 1'b1;
      end
      ST_WSTB: if (last) begin
        state_d = ST_WREC;
        cnt_d   = n_wrec_i - 1'b1;
      end
      ST_RACC: if (last) begin
        state_d = ST_RREC;
        cnt_d   = n_rrec_i - 1'b1;
      end
      ST_WREC, ST_RREC: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctrl_phy.sv
module sram_ctrl_phy #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  accept_i,
  input  logic                  sample_i,
  input  sram_ctrl_pkg::state_e state_d_i,
  input  logic [AW-1:0]         cmd_addr_i,
  input  logic [DW-1:0]         cmd_wdata_i,
  output logic                  rsp_valid_o,
  output logic [DW-1:0]         rsp_rdata_o,
  output logic [AW-1:0]         sram_addr_o,
  output logic                  sram_cs_no,
  output logic                  sram_oe_no,
  output logic                  sram_we_no,
  output logic [DW-1:0]         sram_dq_o,
  input  logic [DW-1:0]         sram_dq_i,
  output logic                  sram_dq_oe_o
);
  import sram_ctrl_pkg::*;

  logic wr_win, rd_win;
  assign wr_win = (state_d_i == ST_WSTB);
  assign rd_win = (state_d_i == ST_RACC);

  // all pad outputs registered; strobes follow next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_cs_no   <= 1'b1;
      sram_we_no   <= 1'b1;
      sram_oe_no   <= 1'b1;
      sram_dq_oe_o <= 1'b0;
    end else begin
      sram_cs_no   <= !(wr_win || rd_win);
      sram_we_no   <= !wr_win;
      sram_oe_no   <= !rd_win;
      sram_dq_oe_o <= wr_win;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
    end else if (accept_i) begin
      sram_addr_o <= cmd_addr_i;
      sram_dq_o   <= cmd_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= sample_i;
      if (sample_i) rsp_rdata_o <= sram_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int unsigned SPEED_GRADE   = 70,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CNT_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_write_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              sram_dq_oe_o
);
  import sram_ctrl_pkg::*;

  logic [CNT_W-1:0] n_wstb, n_wrec, n_racc, n_rrec;
  logic             accept, sample;
  state_e           state_d;

  sram_ctrl_timing #(
    .SPEED_GRADE  (SPEED_GRADE),
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .CNT_W        (CNT_W)
  ) i_timing (
    .n_wstb_o(n_wstb),
    .n_wrec_o(n_wrec),
    .n_racc_o(n_racc),
    .n_rrec_o(n_rrec)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_write_i(cmd_write_i),
    .n_wstb_i   (n_wstb),
    .n_wrec_i   (n_wrec),
    .n_racc_i   (n_racc),
    .n_rrec_i   (n_rrec),
    .cmd_ready_o(cmd_ready_o),
    .accept_o   (accept),
    .sample_o   (sample),
    .state_d_o  (state_d)
  );

  sram_ctrl_phy #(
    .AW(ADDR_W),
    .DW(DATA_W)
  ) i_phy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .sample_i    (sample),
    .state_d_i   (state_d),
    .cmd_addr_i  (cmd_addr_i),
    .cmd_wdata_i (cmd_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .sram_addr_o (sram_addr_o),
    .sram_cs_no  (sram_cs_no),
    .sram_oe_no  (sram_oe_no),
    .sram_we_no  (sram_we_no),
    .sram_dq_o   (sram_dq_o),
    .sram_dq_i   (sram_dq_i),
    .sram_dq_oe_o(sram_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned SPEED_GRADE   = 70,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned ADDR_W        = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic              sram_dq_oe_o
);
  import sram_ctrl_pkg::*;

  localparam int unsigned NWS = wstb_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned NRA = racc_cycles(SPEED_GRADE, CLK_PERIOD_NS);

  logic [15:0] we_lo_cnt, oe_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= sram_we_no ? '0 : we_lo_cnt + 1'b1;
      oe_lo_cnt <= sram_oe_no ? '0 : oe_lo_cnt + 1'b1;
    end
  end

  a_r2_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (sram_cs_no && sram_we_no && sram_oe_no && !sram_dq_oe_o));

  a_r3_cs_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && sram_oe_no) |-> !sram_we_no);

  a_r3_rise_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> $rose(sram_cs_no));

  a_r3_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (we_lo_cnt == 16'(NWS)));

  a_r4_drive_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (!sram_cs_no && !sram_we_no && sram_oe_no));

  a_r6_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(sram_oe_no));

  a_r6_read_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_oe_no) |-> (oe_lo_cnt == 16'(NRA)));

  a_r6_rsp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r8_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && $past(!sram_cs_no)) |-> $stable(sram_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .SPEED_GRADE  (SPEED_GRADE),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .ADDR_W       (ADDR_W)
) i_sram_ctrl_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .sram_addr_o (sram_addr_o),
  .sram_cs_no  (sram_cs_no),
  .sram_oe_no  (sram_oe_no),
  .sram_we_no  (sram_we_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

  localparam int TCK = 8;
  localparam int GRADE = 100;

  function automatic int cdiv(int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // grade 100 limits (ns)
  localparam int N_WS   = mx(mx(cdiv(60), cdiv(80)), mx(cdiv(80), cdiv(40)));
  localparam int N_WC   = cdiv(100);
  localparam int N_WREC = mx(mx(1, cdiv(5)), N_WC - N_WS);
  localparam int N_RA   = mx(mx(cdiv(100), cdiv(100)), cdiv(50));
  localparam int N_RBSY = mx(N_RA + 1, cdiv(100));

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic        cmd_ready_o;
  logic        cmd_write_i = 1'b0;
  logic [18:0] cmd_addr_i = '0;
  logic [7:0]  cmd_wdata_i = '0;
  logic        rsp_valid_o;
  logic [7:0]  rsp_rdata_o;
  logic [18:0] sram_addr_o;
  logic        sram_cs_no, sram_oe_no, sram_we_no;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = '0;
  logic        sram_dq_oe_o;

  always #(TCK/2) clk_i = ~clk_i;

  sram_ctrl #(
    .SPEED_GRADE  (GRADE),
    .CLK_PERIOD_NS(TCK)
  ) i_sram_ctrl (.*);

  int n_chk = 0, n_fail = 0, viol = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  // behavioural RAM
  logic [7:0] ram [logic [18:0]];
  logic [7:0] ref_mem [logic [18:0]];

  function automatic logic [7:0] ram_rd(logic [18:0] a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_rd(logic [18:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  int          wcnt = 0, rcnt = 0, gap = 0;
  bit          in_wr = 0, last_wr = 0, cs_lo_prev = 0;
  logic [18:0] w_addr, r_addr;
  logic [7:0]  w_data;

  always @(negedge clk_i) if (rst_ni) begin
    if (!sram_cs_no && sram_we_no && sram_oe_no) viol++;   // R3
    if (!sram_we_no && sram_cs_no) viol++;                 // R3
    if (sram_dq_oe_o && !sram_oe_no) viol++;               // R4
    // write window
    if (!sram_cs_no && !sram_we_no) begin
      wcnt++;
      if (!sram_dq_oe_o) viol++;                           // R4
      if (wcnt > 1 && (sram_addr_o != w_addr || sram_dq_o != w_data)) viol++; // R8
      w_addr = sram_addr_o;
      w_data = sram_dq_o;
      in_wr  = 1;
    end else if (in_wr) begin
      chk(wcnt == N_WS, "R3 write window cycles", wcnt, N_WS);
      ram[w_addr] = w_data;
      in_wr = 0; wcnt = 0; last_wr = 1; gap = 0;
    end
    // read window
    if (!sram_cs_no && !sram_oe_no && sram_we_no) begin
      if (rcnt > 0 && sram_addr_o != r_addr) viol++;       // R8
      r_addr = sram_addr_o;
      rcnt++;
    end else rcnt = 0;
    // gap after a write
    if (sram_cs_no) gap++;
    if (!sram_cs_no && !cs_lo_prev && last_wr) begin
      chk(gap >= N_WREC && gap + N_WS >= N_WC, "R5 write recovery gap", gap, N_WREC);
      last_wr = 0;
    end
    cs_lo_prev = !sram_cs_no;
    // poisoned until access time met
    sram_dq_i = (rcnt >= N_RA) ? ram_rd(sram_addr_o) : ~ram_rd(sram_addr_o);
  end

  // scoreboard
  typedef struct { logic [7:0] data; int c0; logic [18:0] addr; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk_i) if (rst_ni && rsp_valid_o) begin
    if (exp_q.size() == 0) chk(0, "R6 unexpected response", 1, 0);
    else begin
      exp_t e;
      e = exp_q.pop_front();
      chk(rsp_rdata_o == e.data, "R10 read data", rsp_rdata_o, e.data);
      chk(cyc - e.c0 == N_RA, "R6 read latency", cyc - e.c0, N_RA);
    end
  end

  task automatic do_write(logic [18:0] a, logic [7:0] d, bit hold_other);
    int busy;
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1; cmd_write_i = 1; cmd_addr_i = a; cmd_wdata_i = d;
    @(negedge clk_i);
    ref_mem[a] = d;
    chk(!cmd_ready_o, "R2 ready low after accept", cmd_ready_o, 0);
    if (hold_other) begin
      cmd_addr_i = a ^ 19'h1; cmd_wdata_i = ~d;   // must be ignored
    end else cmd_valid_i = 0;
    busy = 0;
    while (!cmd_ready_o) begin busy++; @(negedge clk_i); end
    cmd_valid_i = 0;
    chk(busy == N_WS + N_WREC, "R5 write busy cycles", busy, N_WS + N_WREC);
  endtask

  task automatic do_read(logic [18:0] a);
    int busy;
    exp_t e;
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_valid_i = 1; cmd_write_i = 0; cmd_addr_i = a;
    @(negedge clk_i);
    cmd_valid_i = 0;
    e.data = ref_rd(a); e.c0 = cyc; e.addr = a;
    exp_q.push_back(e);
    busy = 0;
    while (!cmd_ready_o) begin busy++; @(negedge clk_i); end
    chk(busy == N_RBSY, "R7 read busy cycles", busy, N_RBSY);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(sram_cs_no && sram_we_no && sram_oe_no, "R1 strobes high in reset",
        {sram_cs_no, sram_we_no, sram_oe_no}, 3'b111);
    chk(!sram_dq_oe_o && !rsp_valid_o, "R1 drive and rsp off in reset",
        {sram_dq_oe_o, rsp_valid_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk(cmd_ready_o, "R1 ready after reset", cmd_ready_o, 1);
    chk(N_WS == 10 && N_WREC == 3 && N_RA == 13, "R9 derived counts", N_WS, 10);

    do_write(19'h00000, 8'h00, 0);
    do_write(19'h7FFFF, 8'hFF, 0);
    do_write(19'h12345, 8'h5A, 0);
    do_write(19'h2AAAA, 8'hA5, 0);
    do_write(19'h00555, 8'h3C, 1);   // R2: held request to 0x554 ignored
    do_read(19'h00000);
    do_read(19'h7FFFF);
    do_read(19'h12345);
    do_read(19'h2AAAA);
    do_read(19'h00555);
    do_read(19'h00554);              // R2: expect unwritten value 0
    do_write(19'h12345, 8'h81, 0);
    do_read(19'h12345);              // back-to-back write then read
    for (int i = 0; i < 8; i++) do_write(19'(1) << (i * 2), 8'(1) << i, 0);
    for (int i = 0; i < 8; i++) do_read(19'(1) << (i * 2));

    repeat (N_RBSY + 4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
    chk(viol == 0, "R3 R4 R8 bus protocol violations", viol, 0);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

endmodule